// File: doc/BRIEF.md
# 4x4 Inverse Transform with Reconstruction

This block turns a 4x4 tile of signed 16-bit dequantized coefficients back into pixels. It runs a two-pass separable integer inverse transform, with a vertical pass over the columns and a horizontal pass over the rows. It rounds the residual, adds it to a 4x4 tile of 8-bit prediction pixels, and clamps each sum to the unsigned 8-bit range. The rotation inside each pass uses two fixed-point constants. The sine-like factor is applied to the operand after a small left shift, and only the upper half of the product is kept. The cosine-like factor is stored as its distance from one, so the operand is added back after the multiply.

A caller places all sixteen coefficients and all sixteen prediction pixels on the inputs in parallel and raises `startIn` for one cycle while the block is idle. The block captures both tiles on that edge. It then takes eight cycles: four column steps and four row steps through one shared butterfly. It raises `doneOut` for one cycle when the reconstructed tile on `pixOut` is complete. The tile stays on `pixOut` until the next run overwrites it. Addressing, strides and dequantization belong to the surrounding logic.

Top module: `idct4_recon`

## Requirements
- R1: While `rstN` is low, and right after it is released, `busyOut`, `doneOut` and every bit of `pixOut` are 0.
- R2: When `startIn` is high at a clock edge while `busyOut` is low, `busyOut` is high for exactly the next 8 cycles. `doneOut` is high in the first cycle after those 8, and `busyOut` is low in that cycle.
- R3: The first pass works on each column c. Take x0..x3 as coefficients c, c+4, c+8 and c+12, and form a=x0+x2, b=x0-x2, c'=S(x1)-C(x3) and d=C(x1)+S(x3). Here S(v) is the upper 16 bits of the signed product (v<<2)*8867, and C(v)=v+(upper 16 bits of v*20091). The column then holds a+d, b+c', b-c', a-d from the top row down.
- R4: The second pass applies the same butterfly along each row of the first-pass result. Output k of that butterfly goes to column k of the same row. Each output then has 4 added and is shifted arithmetically right by 3.
- R5: Every intermediate sum, difference, shifted operand and rounding add wraps modulo 2^16 in two's complement. A DC-only coefficient of 32767 therefore gives a residual of -4096.
- R6: Each pixel is the residual plus the zero-extended prediction pixel at the same position, clamped to 0 when negative and to 255 when above 255.
- R7: A `startIn` pulse while `busyOut` is high is ignored. The run still lasts 8 cycles and its result is unchanged.
- R8: `pixOut` does not change in any cycle that follows a cycle in which `busyOut` was low.
- R9: `doneOut` is never high for two cycles in a row.
- R10: Coefficient k sits in `coefIn[16k+15:16k]`, prediction pixel k in `predIn[8k+7:8k]` and output pixel k in `pixOut[8k+7:8k]`, where k = 4*row + column. Both input tiles are sampled only at the accepting edge, so changes to them during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Begin a run; taken only when not busy |
| coefIn | input | 256 | Sixteen signed 16-bit coefficients, raster order |
| predIn | input | 128 | Sixteen 8-bit prediction pixels, raster order |
| busyOut | output | 1 | A run is in progress |
| doneOut | output | 1 | One-cycle pulse: `pixOut` holds a new tile |
| pixOut | output | 128 | Sixteen reconstructed 8-bit pixels, raster order |

## Verification
A start accepted at edge E0 shows `busyOut` from E0 to E8. `doneOut` and the finished tile appear after E8, nine edges after the accepting one. The bench drives inputs on falling edges and counts falling edges from the start pulse. It checks busy on the first and eighth falling edges, and checks the full tile and `doneOut` on the ninth. It checks that `doneOut` has dropped on the tenth. It confirms that the held tile is unchanged three idle cycles later, after the inputs have been scrambled. Expected tiles come either from literal values worked out by hand for single-coefficient, saturating and wrapping cases, or from a bench model of the integer equations.

// File: rtl/idct4_recon_pkg.sv
package idct4_recon_pkg;
  localparam int DIM   = 4;
  localparam int CELLS = DIM * DIM;
  localparam int IDX_W = $clog2(DIM);

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             colPass;
    logic             rowPass;
    logic [IDX_W-1:0] idx;
  } ctrl_t;
endpackage

// File: rtl/idct4_butterfly.sv
module idct4_butterfly #(
  parameter int W            = 16,
  parameter int SIN_K        = 8867,
  parameter int SIN_PRESHIFT = 2,
  parameter int COS_K        = 20091
) (
  input  logic [3:0][W-1:0] xIn,
  output logic [3:0][W-1:0] yOut
);
  localparam logic signed [W-1:0] SIN_KW = SIN_K[W-1:0];
  localparam logic signed [W-1:0] COS_KW = COS_K[W-1:0];

  // upper half of a signed W x W product
  function automatic logic [W-1:0] mulHigh(input logic [W-1:0] v,
                                           input logic signed [W-1:0] k);
    logic signed [2*W-1:0] prod;
    prod = $signed(v) * k;
    return prod[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] sinTerm(input logic [W-1:0] v);
    logic [W-1:0] pre;
    pre = v << SIN_PRESHIFT;
    return mulHigh(pre, SIN_KW);
  endfunction

  function automatic logic [W-1:0] cosTerm(input logic [W-1:0] v);
    return v + mulHigh(v, COS_KW);
  endfunction

  logic [W-1:0] evenSum, evenDiff, oddC, oddD;

  always_comb begin
    evenSum  = xIn[0] + xIn[2];
    evenDiff = xIn[0] - xIn[2];
    oddC     = sinTerm(xIn[1]) - cosTerm(xIn[3]);
    oddD     = cosTerm(xIn[1]) + sinTerm(xIn[3]);
    yOut[0]  = evenSum + oddD;
    yOut[1]  = evenDiff + oddC;
    yOut[2]  = evenDiff - oddC;
    yOut[3]  = evenSum - oddD;
  end
endmodule

// File: rtl/idct4_ctrl.sv
module idct4_ctrl
  import idct4_recon_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  startIn,
  output ctrl_t ctrl,
  output logic  busyOut,
  output logic  doneOut
);
  typedef enum logic [1:0] {ST_IDLE, ST_COLS, ST_ROWS} state_t;

  state_t           state;
  logic [IDX_W-1:0] stepCnt;
  logic             lastStep;

  assign lastStep = (stepCnt == IDX_W'(DIM - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      case (state)
        ST_IDLE: begin
          stepCnt <= '0;
          if (startIn) state <= ST_COLS;
        end
        ST_COLS: begin
          stepCnt <= stepCnt + 1'b1;
          if (lastStep) state <= ST_ROWS;
        end
        ST_ROWS: begin
          stepCnt <= stepCnt + 1'b1;
          if (lastStep) begin
            state   <= ST_IDLE;
            doneOut <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load    = (state == ST_IDLE) && startIn;
    ctrl.colPass = (state == ST_COLS);
    ctrl.rowPass = (state == ST_ROWS);
    ctrl.idx     = stepCnt;
  end

  assign busyOut = (state != ST_IDLE);
endmodule

// File: rtl/idct4_datapath.sv
module idct4_datapath
  import idct4_recon_pkg::*;
#(
  parameter int COEF_W       = 16,
  parameter int PIX_W        = 8,
  parameter int SIN_K        = 8867,
  parameter int SIN_PRESHIFT = 2,
  parameter int COS_K        = 20091,
  parameter int ROUND_SHIFT  = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_t                     ctrl,
  input  logic [CELLS*COEF_W-1:0]   coefIn,
  input  logic [CELLS*PIX_W-1:0]    predIn,
  output logic [CELLS*PIX_W-1:0]    pixOut
);
  localparam logic [COEF_W-1:0] ROUND_ADD = COEF_W'(1 << (ROUND_SHIFT - 1));

  logic [CELLS-1:0][COEF_W-1:0] coefReg;
  logic [CELLS-1:0][COEF_W-1:0] midReg;
  logic [CELLS-1:0][PIX_W-1:0]  predReg;
  logic [CELLS-1:0][PIX_W-1:0]  pixReg;

  logic [3:0][COEF_W-1:0] bfIn, bfOut;
  logic [3:0][PIX_W-1:0]  pixNext;

  // column step reads a coefficient column, row step reads a mid-result row
  always_comb begin
    for (int k = 0; k < DIM; k++) begin
      if (ctrl.colPass) bfIn[k] = coefReg[k*DIM + int'(ctrl.idx)];
      else              bfIn[k] = midReg[int'(ctrl.idx)*DIM + k];
    end
  end

  idct4_butterfly #(
    .W(COEF_W), .SIN_K(SIN_K), .SIN_PRESHIFT(SIN_PRESHIFT), .COS_K(COS_K)
  ) u_bfly (
    .xIn(bfIn),
    .yOut(bfOut)
  );

  // round, add prediction, clamp: one lane per column of the current row
  for (genvar k = 0; k < DIM; k++) begin : g_recon
    logic [COEF_W-1:0]        rounded;
    logic signed [COEF_W-1:0] resid;
    logic signed [COEF_W-1:0] total;
    logic [PIX_W-1:0]         predSel;

    always_comb begin
      predSel = predReg[int'(ctrl.idx)*DIM + k];
      rounded = bfOut[k] + ROUND_ADD;
      resid   = $signed(rounded) >>> ROUND_SHIFT;
      total   = resid + $signed({{(COEF_W-PIX_W){1'b0}}, predSel});
      if (total[COEF_W-1])               pixNext[k] = '0;
      else if (|total[COEF_W-2:PIX_W])   pixNext[k] = '1;
      else                               pixNext[k] = total[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefReg <= '0;
      predReg <= '0;
      midReg  <= '0;
      pixReg  <= '0;
    end else begin
      if (ctrl.load) begin
        coefReg <= coefIn;
        predReg <= predIn;
      end
      if (ctrl.colPass) begin
        for (int k = 0; k < DIM; k++)
          midReg[k*DIM + int'(ctrl.idx)] <= bfOut[k];
      end
      if (ctrl.rowPass) begin
        for (int k = 0; k < DIM; k++)
          pixReg[int'(ctrl.idx)*DIM + k] <= pixNext[k];
      end
    end
  end

  assign pixOut = pixReg;
endmodule

// File: rtl/idct4_recon.sv
module idct4_recon
  import idct4_recon_pkg::*;
#(
  parameter int COEF_W       = 16,
  parameter int PIX_W        = 8,
  parameter int SIN_K        = 8867,
  parameter int SIN_PRESHIFT = 2,
  parameter int COS_K        = 20091,
  parameter int ROUND_SHIFT  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startIn,
  input  logic [16*COEF_W-1:0]    coefIn,
  input  logic [16*PIX_W-1:0]     predIn,
  output logic                    busyOut,
  output logic                    doneOut,
  output logic [16*PIX_W-1:0]     pixOut
);
  ctrl_t ctrl;

  idct4_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .ctrl(ctrl), .busyOut(busyOut), .doneOut(doneOut)
  );

  idct4_datapath #(
    .COEF_W(COEF_W), .PIX_W(PIX_W), .SIN_K(SIN_K),
    .SIN_PRESHIFT(SIN_PRESHIFT), .COS_K(COS_K), .ROUND_SHIFT(ROUND_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .coefIn(coefIn), .predIn(predIn), .pixOut(pixOut)
  );
endmodule

// File: rtl/idct4_recon_chk.sv
module idct4_recon_chk #(
  parameter int PIX_BITS = 128,
  parameter int RUN_LEN  = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                startIn,
  input logic                busyOut,
  input logic                doneOut,
  input logic [PIX_BITS-1:0] pixOut
);
  logic [7:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else       busyRun <= busyOut ? busyRun + 1'b1 : 8'd0;
  end

  // R2: an idle start is accepted on the next edge
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyOut) |=> busyOut);

  // R2: done shows only as busy falls
  p_done_at_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (!busyOut && $past(busyOut)));

  // R7: a run never lasts longer than its fixed length, late starts included
  p_run_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 8'(RUN_LEN));

  // R7: every run ends after exactly its fixed length
  p_run_exact_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOut && $past(busyOut)) |-> (busyRun == 8'(RUN_LEN)));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R8: the tile holds across idle cycles
  p_pix_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut |=> $stable(pixOut));
endmodule

bind idct4_recon idct4_recon_chk #(.PIX_BITS(16*PIX_W), .RUN_LEN(8)) u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .busyOut(busyOut),
  .doneOut(doneOut), .pixOut(pixOut)
);

// File: tb/test_idct4_recon.sv
module test_idct4_recon;
  logic         clk = 1'b0;
  logic         rstN;
  logic         startIn;
  logic [255:0] coefIn;
  logic [127:0] predIn;
  logic         busyOut, doneOut;
  logic [127:0] pixOut;

  int nChecks = 0;
  int nBad    = 0;
  int coefA[16];
  int predA[16];
  int expA[16];

  always #5 clk = ~clk;

  idct4_recon i_idct4_recon (
    .clk(clk), .rstN(rstN), .startIn(startIn), .coefIn(coefIn),
    .predIn(predIn), .busyOut(busyOut), .doneOut(doneOut), .pixOut(pixOut)
  );

  typedef struct packed { int dc; int ac; int pred; } vec_t;
  localparam vec_t TABLE [0:5] = '{
    '{dc: 0,     ac: 0,    pred: 77},
    '{dc: 300,   ac: -20,  pred: 10},
    '{dc: -500,  ac: 45,   pred: 200},
    '{dc: 1500,  ac: -100, pred: 128},
    '{dc: -1024, ac: 200,  pred: 5},
    '{dc: 2047,  ac: -150, pred: 250}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---- bench model of the integer equations ----
  function automatic int w16(input int v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic int sinT(input int v);
    return w16((w16(v * 4) * 8867) >>> 16);
  endfunction

  function automatic int cosT(input int v);
    return w16(v + ((v * 20091) >>> 16));
  endfunction

  task automatic bfly(input int x0, input int x1, input int x2, input int x3,
                      output int y0, output int y1, output int y2, output int y3);
    int a, b, c, d;
    a = w16(x0 + x2);
    b = w16(x0 - x2);
    c = w16(sinT(x1) - cosT(x3));
    d = w16(cosT(x1) + sinT(x3));
    y0 = w16(a + d); y1 = w16(b + c); y2 = w16(b - c); y3 = w16(a - d);
  endtask

  task automatic computeExpected();
    int mid[16];
    int o[4];
    for (int c = 0; c < 4; c++)
      bfly(coefA[c], coefA[4+c], coefA[8+c], coefA[12+c],
           mid[c], mid[4+c], mid[8+c], mid[12+c]);
    for (int r = 0; r < 4; r++) begin
      bfly(mid[4*r], mid[4*r+1], mid[4*r+2], mid[4*r+3], o[0], o[1], o[2], o[3]);
      for (int k = 0; k < 4; k++) begin
        int s;
        s = w16(predA[4*r+k] + (w16(o[k] + 4) >>> 3));
        expA[4*r+k] = (s < 0) ? 0 : ((s > 255) ? 255 : s);
      end
    end
  endtask

  task automatic clearTiles(input int predVal);
    for (int k = 0; k < 16; k++) begin coefA[k] = 0; predA[k] = predVal; end
  endtask

  // start at falling edge n0; result due at falling edge n9
  task automatic runBlock(input string req, input bit disturb);
    logic [127:0] held;
    int badIdx;
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      coefIn[16*k +: 16] = coefA[k][15:0];
      predIn[8*k +: 8]   = predA[k][7:0];
    end
    startIn = 1'b1;
    @(negedge clk);
    startIn = disturb;
    check(busyOut === 1'b1, "R2", "busy one cycle after start", int'(busyOut), 1);
    if (disturb) begin coefIn = ~coefIn; predIn = ~predIn; end
    for (int n = 2; n <= 8; n++) begin
      @(negedge clk);
      if (n == 4) startIn = 1'b0;
    end
    check(busyOut === 1'b1 && doneOut === 1'b0, "R2", "busy and not done at 8th cycle",
          int'(busyOut), 1);
    @(negedge clk);
    check(doneOut === 1'b1, "R2", "done at 9th cycle", int'(doneOut), 1);
    check(busyOut === 1'b0, "R2", "idle at 9th cycle", int'(busyOut), 0);
    badIdx = -1;
    for (int k = 0; k < 16; k++)
      if (pixOut[8*k +: 8] !== expA[k][7:0] && badIdx < 0) badIdx = k;
    if (badIdx < 0) check(1'b1, req, "tile", 0, 0);
    else check(1'b0, req, $sformatf("pixel %0d", badIdx),
               int'(pixOut[8*badIdx +: 8]), expA[badIdx]);
    held = pixOut;
    @(negedge clk);
    check(doneOut === 1'b0, "R9", "done drops after one cycle", int'(doneOut), 0);
    coefIn = {8{$urandom()}};
    predIn = {4{$urandom()}};
    repeat (3) @(negedge clk);
    check(pixOut === held, "R8", "tile held while idle", int'(pixOut[31:0]), int'(held[31:0]));
  endtask

  initial begin
    rstN = 1'b0; startIn = 1'b0; coefIn = '0; predIn = '0;
    repeat (3) @(negedge clk);
    check(busyOut === 1'b0, "R1", "busy in reset", int'(busyOut), 0);
    check(doneOut === 1'b0, "R1", "done in reset", int'(doneOut), 0);
    check(pixOut === '0, "R1", "pixels in reset", int'(pixOut[31:0]), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busyOut === 1'b0 && pixOut === '0, "R1", "state after release",
          int'(busyOut), 0);

    // table walk: patterned tiles against the model (R3, R4, R6, R10)
    foreach (TABLE[i]) begin
      for (int k = 0; k < 16; k++) begin
        coefA[k] = (k == 0) ? TABLE[i].dc : w16(TABLE[i].ac * (k - 7));
        predA[k] = (TABLE[i].pred + 13 * k) & 255;
      end
      computeExpected();
      runBlock("R3 R4 table", 1'b0);
    end

    // R3: single coefficient at row 1 column 0 exercises the column rotation
    clearTiles(128); coefA[4] = 100;
    for (int k = 0; k < 16; k++)
      expA[k] = (k < 4) ? 144 : (k < 8) ? 135 : (k < 12) ? 121 : 112;
    runBlock("R3", 1'b0);

    // R4 / R10: same value at row 0 column 1 spreads across columns
    clearTiles(128); coefA[1] = 100;
    for (int k = 0; k < 16; k++) begin
      int c;
      c = k % 4;
      expA[k] = (c == 0) ? 144 : (c == 1) ? 135 : (c == 2) ? 121 : 112;
    end
    runBlock("R4", 1'b0);

    // R6: in-range DC, high clamp, low clamp
    clearTiles(100); coefA[0] = 80;
    for (int k = 0; k < 16; k++) expA[k] = 110;
    runBlock("R6", 1'b0);
    clearTiles(200); coefA[0] = 2040;
    for (int k = 0; k < 16; k++) expA[k] = 255;
    runBlock("R6", 1'b0);
    clearTiles(50); coefA[0] = -2048;
    for (int k = 0; k < 16; k++) expA[k] = 0;
    runBlock("R6", 1'b0);

    // R5: rounding add wraps, giving a large negative residual
    clearTiles(100); coefA[0] = 32767;
    for (int k = 0; k < 16; k++) expA[k] = 0;
    runBlock("R5", 1'b0);

    // R7 / R10: start pulses and input changes during a run are ignored
    for (int k = 0; k < 16; k++) begin
      coefA[k] = int'($urandom_range(4095)) - 2048;
      predA[k] = int'($urandom_range(255));
    end
    computeExpected();
    runBlock("R7 R10", 1'b1);

    // random tiles against the model
    for (int t = 0; t < 16; t++) begin
      for (int k = 0; k < 16; k++) begin
        coefA[k] = int'($urandom_range(4095)) - 2048;
        predA[k] = int'($urandom_range(255));
      end
      computeExpected();
      runBlock("R3 R4 R6 random", 1'b0);
    end

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule